// File: doc/BRIEF.md
# Store-Bypass Ordering Guard

This block guards the memory ordering of a small load/store queue. It decides whether a younger load may issue while some older stores still have unknown addresses. If a load does go ahead of such a store and that store later turns out to write the same 8-byte word, the load has read a stale value. The block then names that load so that the pipeline can replay it.

The store side is an in-order ring. Stores enter at the tail, receive an address later and in any order, and leave from the head. A flush cuts the ring back behind a given store. Each load presents a snapshot of the store tail taken at dispatch, which tells the block which stores are older than the load. A granted load records which older stores were still unresolved at that moment. When a store resolves, its address is compared only against loads that recorded that store. Two controls can withhold the grant. The first is a global input that turns speculative bypassing off. The second is a barrier, which holds loads back until every store present when the barrier was inserted has an address.

Top module: `sbc_bypass_guard`

## Requirements
- R1: After reset the store ring is empty (`sq_tail_o` = 0), `replay_o` is low, and a load request is granted in the same cycle.
- R2: With bypassing enabled and no barrier pending, a load request is granted in its request cycle even when older stores are unresolved, and `ld_stall_o` stays low.
- R3: When a store resolves to an address whose bits [31:3] equal those of a load that was granted while that store was older and unresolved, `replay_o` is high in the cycle after the resolve, with `replay_slot_o` naming the load's slot. It is low again one cycle later.
- R4: A resolve whose address differs from the load's in any of bits [31:3] raises no replay. Differences only in bits [2:0] still count as a match.
- R5: Only stores allocated before the load's tail snapshot are older. A younger store neither stalls the load nor triggers a replay of it.
- R6: While `bypass_off_i` is high, a load with any older unresolved store gets `ld_stall_o` and no grant. Once those stores have resolved, the load is granted.
- R7: After `barrier_i` is pulsed, loads with unresolved older stores are stalled until every store that was valid at the barrier has resolved. Stores allocated after the barrier do not hold the barrier.
- R8: If several recorded loads match one resolve, only the oldest is reported. Age counts circularly from slot `lq_head_i` upward.
- R9: An allocation while 8 stores are held is ignored (`sq_tail_o` unchanged). A retire frees the oldest store, and the next allocation is then accepted.
- R10: A flush with tag T removes every store younger than T and sets `sq_tail_o` to one past T. The removed stores no longer stall loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_off_i | input | 1 | Global disable of speculative store bypassing |
| st_alloc_i | input | 1 | Allocate a store at the tail |
| st_resolve_i | input | 1 | A store address becomes known |
| st_resolve_tag_i | input | 3 | Store ring index being resolved |
| st_resolve_addr_i | input | 32 | Resolved store address |
| st_retire_i | input | 1 | Retire the oldest store |
| flush_i | input | 1 | Remove stores younger than `flush_tag_i` |
| flush_tag_i | input | 3 | Youngest surviving store index |
| barrier_i | input | 1 | Insert a bypass barrier |
| ld_req_i | input | 1 | Load issue request |
| ld_slot_i | input | 3 | Load queue slot of the request |
| ld_sq_tail_i | input | 4 | Store tail snapshot (with wrap bit) taken at load dispatch |
| ld_addr_i | input | 32 | Load address |
| lq_head_i | input | 3 | Slot of the oldest load in the load queue |
| ld_grant_o | output | 1 | Load may issue this cycle |
| ld_stall_o | output | 1 | Load must wait |
| replay_o | output | 1 | A load read a stale value and must replay |
| replay_slot_o | output | 3 | Slot of the load to replay |
| sq_tail_o | output | 4 | Store tail pointer with wrap bit; the next store gets its low 3 bits |

## Verification
Grant and stall are combinational, so they are judged in the request cycle itself: the bench drives the request on a falling edge and reads them a moment later. A replay is registered on the same edge that captures the resolve, so it is sampled on the falling edge right after that edge, and it is checked low again one cycle later. The tail pointer changes on the edge that takes an allocate, retire or flush, and it is compared on the falling edge that follows. Bench bookkeeping of tags is kept independent of the design.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

   // Default geometry of the guarded queues
   localparam int unsigned SBC_SQ_DEPTH = 8;
   localparam int unsigned SBC_LQ_DEPTH = 8;
   localparam int unsigned SBC_ADDR_W   = 32;
   localparam int unsigned SBC_WORD_LSB = 3;

   // Why a load request was held back
   typedef enum logic [1:0] {
      HOLD_NONE    = 2'd0,
      HOLD_DISABLE = 2'd1,
      HOLD_BARRIER = 2'd2
   } sbc_hold_e;

endpackage

// File: rtl/sbc_store_ring.sv
module sbc_store_ring #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned IW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc,
   input  logic             resolve,
   input  logic [IW-1:0]    res_tag,
   input  logic             retire,
   input  logic             flush,
   input  logic [IW-1:0]    flush_tag,
   input  logic             barrier,
   output logic [IW:0]      head,
   output logic [IW:0]      tail,
   output logic [DEPTH-1:0] unres,
   output logic             fence_pend
);

   logic [IW:0]      head_q, tail_q;
   logic [DEPTH-1:0] vld_q, res_q, fence_q;
   logic [DEPTH-1:0] res_now;
   logic [IW:0]      count;
   logic             alloc_ok;
   logic             retire_ok;
   logic [IW-1:0]    flush_off;
   logic [IW:0]      keep_n;

   assign count     = tail_q - head_q;
   assign alloc_ok  = alloc & ~flush & (count < (IW+1)'(DEPTH));
   assign retire_ok = retire & vld_q[head_q[IW-1:0]];
   assign flush_off = flush_tag - head_q[IW-1:0];
   assign keep_n    = {1'b0, flush_off} + (IW+1)'(1);

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [IW-1:0] off;
      logic          kill, ret_i, alc_i;
      assign off        = IW'(i) - head_q[IW-1:0];
      assign kill       = flush & vld_q[i] & (off > flush_off);
      assign ret_i      = retire_ok & (head_q[IW-1:0] == IW'(i));
      assign alc_i      = alloc_ok & (tail_q[IW-1:0] == IW'(i));
      assign res_now[i] = resolve & (res_tag == IW'(i)) & vld_q[i];
      assign unres[i]   = vld_q[i] & ~res_q[i] & ~res_now[i];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[i]   <= 1'b0;
            res_q[i]   <= 1'b0;
            fence_q[i] <= 1'b0;
         end else if (alc_i) begin
            vld_q[i]   <= 1'b1;
            res_q[i]   <= 1'b0;
            fence_q[i] <= 1'b0;
         end else begin
            if (ret_i | kill) vld_q[i] <= 1'b0;
            if (res_now[i])   res_q[i] <= 1'b1;
            fence_q[i] <= (fence_q[i] | (barrier & vld_q[i] & ~res_q[i]))
                          & ~(res_now[i] | ret_i | kill);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         if (retire_ok) head_q <= head_q + (IW+1)'(1);
         if (flush)         tail_q <= head_q + keep_n;
         else if (alloc_ok) tail_q <= tail_q + (IW+1)'(1);
      end
   end

   assign head       = head_q;
   assign tail       = tail_q;
   assign fence_pend = |(fence_q & ~res_now);

endmodule

// File: rtl/sbc_load_table.sv
module sbc_load_table #(
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned SQ_DEPTH = 8,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned LSB     = 3,
   localparam int unsigned LW     = $clog2(DEPTH),
   localparam int unsigned SW     = $clog2(SQ_DEPTH),
   localparam int unsigned KW     = ADDR_W - LSB
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                issue,
   input  logic [LW-1:0]       slot,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [SQ_DEPTH-1:0] mask,
   input  logic                resolve,
   input  logic [SW-1:0]       res_tag,
   input  logic [ADDR_W-1:0]   res_addr,
   input  logic [SQ_DEPTH-1:0] sq_unres,
   input  logic                clr,
   input  logic [LW-1:0]       clr_slot,
   output logic [DEPTH-1:0]    hit
);

   logic [DEPTH-1:0]    lv_q;
   logic [KW-1:0]       key_q  [DEPTH];
   logic [SQ_DEPTH-1:0] mask_q [DEPTH];

   for (genvar j = 0; j < DEPTH; j++) begin : g_ld
      assign hit[j] = lv_q[j] & resolve & mask_q[j][res_tag]
                      & (key_q[j] == res_addr[ADDR_W-1:LSB]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lv_q[j]   <= 1'b0;
            key_q[j]  <= '0;
            mask_q[j] <= '0;
         end else if (issue && slot == LW'(j)) begin
            lv_q[j]   <= 1'b1;
            key_q[j]  <= addr[ADDR_W-1:LSB];
            mask_q[j] <= mask;
         end else begin
            mask_q[j] <= mask_q[j] & sq_unres;
            if (clr && clr_slot == LW'(j)) lv_q[j] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sbc_oldest_pick.sv
module sbc_oldest_pick #(
   parameter int unsigned N = 8,
   localparam int unsigned W = $clog2(N)
) (
   input  logic [N-1:0] req,
   input  logic [W-1:0] base,
   output logic         found,
   output logic [W-1:0] idx
);

   logic [W-1:0] cand;

   always_comb begin
      found = 1'b0;
      idx   = '0;
      cand  = '0;
      for (int k = 0; k < N; k++) begin
         cand = base + W'(k);
         if (!found && req[cand]) begin
            found = 1'b1;
            idx   = cand;
         end
      end
   end

endmodule

// File: rtl/sbc_bypass_guard.sv
module sbc_bypass_guard
   import sbc_pkg::*;
#(
   parameter int unsigned SQ_DEPTH = SBC_SQ_DEPTH,
   parameter int unsigned LQ_DEPTH = SBC_LQ_DEPTH,
   parameter int unsigned ADDR_W   = SBC_ADDR_W,
   parameter int unsigned WORD_LSB = SBC_WORD_LSB,
   localparam int unsigned SW      = $clog2(SQ_DEPTH),
   localparam int unsigned LW      = $clog2(LQ_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bypass_off_i,
   input  logic              st_alloc_i,
   input  logic              st_resolve_i,
   input  logic [SW-1:0]     st_resolve_tag_i,
   input  logic [ADDR_W-1:0] st_resolve_addr_i,
   input  logic              st_retire_i,
   input  logic              flush_i,
   input  logic [SW-1:0]     flush_tag_i,
   input  logic              barrier_i,
   input  logic              ld_req_i,
   input  logic [LW-1:0]     ld_slot_i,
   input  logic [SW:0]       ld_sq_tail_i,
   input  logic [ADDR_W-1:0] ld_addr_i,
   input  logic [LW-1:0]     lq_head_i,
   output logic              ld_grant_o,
   output logic              ld_stall_o,
   output logic              replay_o,
   output logic [LW-1:0]     replay_slot_o,
   output logic [SW:0]       sq_tail_o
);

   if ((SQ_DEPTH < 2) || ((SQ_DEPTH & (SQ_DEPTH - 1)) != 0)) begin : g_bad_sq
      $error("SQ_DEPTH must be a power of two of at least 2");
   end
   if ((LQ_DEPTH < 2) || ((LQ_DEPTH & (LQ_DEPTH - 1)) != 0)) begin : g_bad_lq
      $error("LQ_DEPTH must be a power of two of at least 2");
   end
   if (WORD_LSB >= ADDR_W) begin : g_bad_lsb
      $error("WORD_LSB must lie below ADDR_W");
   end

   logic [SW:0]          sq_head;
   logic [SQ_DEPTH-1:0]  sq_unres;
   logic                 fence_pend;
   logic [SQ_DEPTH-1:0]  older_unres;
   logic [SW:0]          ld_span;
   logic                 span_ok;
   logic [LQ_DEPTH-1:0]  ld_hit;
   logic                 pick_found;
   logic [LW-1:0]        pick_idx;
   sbc_hold_e            hold;
   logic                 replay_q;
   logic [LW-1:0]        replay_slot_q;

   sbc_store_ring #(.DEPTH(SQ_DEPTH)) u_ring (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (st_alloc_i),
      .resolve    (st_resolve_i),
      .res_tag    (st_resolve_tag_i),
      .retire     (st_retire_i),
      .flush      (flush_i),
      .flush_tag  (flush_tag_i),
      .barrier    (barrier_i),
      .head       (sq_head),
      .tail       (sq_tail_o),
      .unres      (sq_unres),
      .fence_pend (fence_pend)
   );

   // Stores older than the load lie between the head and its tail snapshot
   assign ld_span = ld_sq_tail_i - sq_head;
   assign span_ok = ld_span <= (SW+1)'(SQ_DEPTH);

   for (genvar i = 0; i < SQ_DEPTH; i++) begin : g_age
      logic [SW-1:0] off;
      assign off            = SW'(i) - sq_head[SW-1:0];
      assign older_unres[i] = sq_unres[i] & span_ok & ({1'b0, off} < ld_span);
   end

   always_comb begin
      hold = HOLD_NONE;
      if (|older_unres) begin
         if (bypass_off_i)    hold = HOLD_DISABLE;
         else if (fence_pend) hold = HOLD_BARRIER;
      end
   end

   assign ld_grant_o = ld_req_i & (hold == HOLD_NONE);
   assign ld_stall_o = ld_req_i & (hold != HOLD_NONE);

   sbc_load_table #(
      .DEPTH    (LQ_DEPTH),
      .SQ_DEPTH (SQ_DEPTH),
      .ADDR_W   (ADDR_W),
      .LSB      (WORD_LSB)
   ) u_ldtab (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue    (ld_grant_o),
      .slot     (ld_slot_i),
      .addr     (ld_addr_i),
      .mask     (older_unres),
      .resolve  (st_resolve_i),
      .res_tag  (st_resolve_tag_i),
      .res_addr (st_resolve_addr_i),
      .sq_unres (sq_unres),
      .clr      (pick_found),
      .clr_slot (pick_idx),
      .hit      (ld_hit)
   );

   sbc_oldest_pick #(.N(LQ_DEPTH)) u_pick (
      .req   (ld_hit),
      .base  (lq_head_i),
      .found (pick_found),
      .idx   (pick_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         replay_q      <= 1'b0;
         replay_slot_q <= '0;
      end else begin
         replay_q      <= pick_found;
         replay_slot_q <= pick_found ? pick_idx : replay_slot_q;
      end
   end

   assign replay_o      = replay_q;
   assign replay_slot_o = replay_slot_q;

endmodule

// File: rtl/sbc_bypass_guard_chk.sv
module sbc_bypass_guard_chk #(
   parameter int unsigned SQ_DEPTH = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ld_req_i,
   input logic                ld_grant_o,
   input logic                ld_stall_o,
   input logic                replay_o,
   input logic                st_resolve_i,
   input logic                bypass_off_i,
   input logic                fence_pend,
   input logic [SQ_DEPTH-1:0] older_unres
);

   // R2
   grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_grant_o | ld_stall_o) |-> ld_req_i);

   // R2
   grant_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_grant_o && ld_stall_o));

   // R3
   replay_after_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      replay_o |-> $past(st_resolve_i));

   // R6
   disable_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bypass_off_i && (older_unres != '0)) |-> !ld_grant_o);

   // R7
   barrier_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fence_pend && (older_unres != '0)) |-> !ld_grant_o);

endmodule

bind sbc_bypass_guard sbc_bypass_guard_chk #(.SQ_DEPTH(SQ_DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ld_req_i     (ld_req_i),
   .ld_grant_o   (ld_grant_o),
   .ld_stall_o   (ld_stall_o),
   .replay_o     (replay_o),
   .st_resolve_i (st_resolve_i),
   .bypass_off_i (bypass_off_i),
   .fence_pend   (fence_pend),
   .older_unres  (older_unres)
);

// File: tb/sbc_bypass_guard_tb_top.sv
module sbc_bypass_guard_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bypass_off_i, st_alloc_i, st_resolve_i, st_retire_i;
   logic [2:0]  st_resolve_tag_i, flush_tag_i, ld_slot_i, lq_head_i;
   logic [31:0] st_resolve_addr_i, ld_addr_i;
   logic        flush_i, barrier_i, ld_req_i;
   logic [3:0]  ld_sq_tail_i;
   logic        ld_grant_o, ld_stall_o, replay_o;
   logic [2:0]  replay_slot_o;
   logic [3:0]  sq_tail_o;

   always #5 clk = ~clk;

   sbc_bypass_guard dut_i (
      .clk(clk), .rst_n(rst_n), .bypass_off_i(bypass_off_i),
      .st_alloc_i(st_alloc_i), .st_resolve_i(st_resolve_i),
      .st_resolve_tag_i(st_resolve_tag_i), .st_resolve_addr_i(st_resolve_addr_i),
      .st_retire_i(st_retire_i), .flush_i(flush_i), .flush_tag_i(flush_tag_i),
      .barrier_i(barrier_i), .ld_req_i(ld_req_i), .ld_slot_i(ld_slot_i),
      .ld_sq_tail_i(ld_sq_tail_i), .ld_addr_i(ld_addr_i), .lq_head_i(lq_head_i),
      .ld_grant_o(ld_grant_o), .ld_stall_o(ld_stall_o), .replay_o(replay_o),
      .replay_slot_o(replay_slot_o), .sq_tail_o(sq_tail_o)
   );

   int checks = 0;
   int errors = 0;
   logic [3:0] bt = '0;

   // {load address, store address, replay expected}
   localparam logic [64:0] VEC [0:5] = '{
      {32'h0000_1000, 32'h0000_1000, 1'b1},
      {32'h0000_1000, 32'h0000_1007, 1'b1},
      {32'h0000_1003, 32'h0000_1000, 1'b1},
      {32'h0000_1000, 32'h0000_1008, 1'b0},
      {32'h0000_1008, 32'h0000_1000, 1'b0},
      {32'h8000_1000, 32'h0000_1000, 1'b0}
   };

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   task automatic alloc();
      st_alloc_i = 1'b1; step(); st_alloc_i = 1'b0;
      bt = bt + 4'd1;
   endtask

   task automatic resolve(input logic [2:0] tag, input logic [31:0] a);
      st_resolve_i = 1'b1; st_resolve_tag_i = tag; st_resolve_addr_i = a;
      step();
      st_resolve_i = 1'b0;
   endtask

   task automatic retire();
      st_retire_i = 1'b1; step(); st_retire_i = 1'b0;
   endtask

   task automatic issue(input logic [2:0] slot, input logic [3:0] snap,
                        input logic [31:0] a, input logic exp, input string r);
      ld_req_i = 1'b1; ld_slot_i = slot; ld_sq_tail_i = snap; ld_addr_i = a;
      #1;
      chk(r, ld_grant_o, exp);
      chk(r, ld_stall_o, !exp);
      step();
      ld_req_i = 1'b0;
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [2:0] ta, tb, t0;
      logic [3:0] start;
      rst_n = 1'b0; bypass_off_i = 0; st_alloc_i = 0; st_resolve_i = 0;
      st_retire_i = 0; flush_i = 0; barrier_i = 0; ld_req_i = 0;
      st_resolve_tag_i = 0; st_resolve_addr_i = 0; flush_tag_i = 0;
      ld_slot_i = 0; ld_sq_tail_i = 0; ld_addr_i = 0; lq_head_i = 0;
      @(negedge clk); step(); step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      chk("R1 tail", sq_tail_o, 4'd0);
      chk("R1 replay", replay_o, 1'b0);
      issue(3'd7, 4'd0, 32'h40, 1'b1, "R1 grant");

      // R3 / R4 vector walk, each load bypasses one store (R2)
      foreach (VEC[v]) begin
         ta = bt[2:0];
         alloc();
         issue(3'd0, bt, VEC[v][64:33], 1'b1, "R2 bypass grant");
         resolve(ta, VEC[v][32:1]);
         chk(VEC[v][0] ? "R3 replay" : "R4 no replay", replay_o, VEC[v][0]);
         if (VEC[v][0]) chk("R3 slot", replay_slot_o, 3'd0);
         retire();
         chk("R3 pulse ends", replay_o, 1'b0);
      end

      // R5 younger store is not older than the load
      start = bt;
      ta = bt[2:0];
      alloc();
      issue(3'd1, start, 32'h2000, 1'b1, "R5 younger grant");
      resolve(ta, 32'h2000);
      chk("R5 no replay", replay_o, 1'b0);
      retire();

      // R6 global disable
      bypass_off_i = 1'b1;
      start = bt;
      ta = bt[2:0];
      alloc();
      issue(3'd1, bt, 32'h2100, 1'b0, "R6 stall");
      issue(3'd1, start, 32'h2100, 1'b1, "R5 younger under disable");
      resolve(ta, 32'h2200);
      issue(3'd1, bt, 32'h2100, 1'b1, "R6 grant after resolve");
      retire();
      bypass_off_i = 1'b0;

      // R7 barrier
      ta = bt[2:0];
      alloc();
      barrier_i = 1'b1; step(); barrier_i = 1'b0;
      tb = bt[2:0];
      alloc();
      issue(3'd1, bt, 32'h2000, 1'b0, "R7 barrier stall");
      resolve(ta, 32'h3000);
      issue(3'd1, bt, 32'h2000, 1'b1, "R7 grant after older resolve");
      resolve(tb, 32'h4000);
      chk("R7 no replay", replay_o, 1'b0);
      retire(); retire();

      // R8 oldest matching load
      ta = bt[2:0];
      alloc();
      lq_head_i = 3'd4;
      issue(3'd2, bt, 32'h5000, 1'b1, "R8 issue");
      issue(3'd5, bt, 32'h5004, 1'b1, "R8 issue");
      issue(3'd6, bt, 32'h6000, 1'b1, "R8 issue");
      resolve(ta, 32'h5000);
      chk("R8 replay", replay_o, 1'b1);
      chk("R8 oldest head4", replay_slot_o, 3'd5);
      retire();
      tb = bt[2:0];
      alloc();
      lq_head_i = 3'd1;
      issue(3'd2, bt, 32'h5000, 1'b1, "R8 issue");
      issue(3'd5, bt, 32'h5000, 1'b1, "R8 issue");
      resolve(tb, 32'h5000);
      chk("R8 replay", replay_o, 1'b1);
      chk("R8 oldest head1", replay_slot_o, 3'd2);
      retire();
      lq_head_i = 3'd0;

      // R9 full ring and retire
      start = bt;
      for (int k = 0; k < 8; k++) alloc();
      st_alloc_i = 1'b1; step(); st_alloc_i = 1'b0;
      chk("R9 full ignores alloc", sq_tail_o, bt);
      bypass_off_i = 1'b1;
      issue(3'd3, bt, 32'h7000, 1'b0, "R6 stall full");
      for (int k = 0; k < 8; k++) resolve(3'(start + 4'(k)), 32'h9000);
      retire();
      ta = bt[2:0];
      alloc();
      chk("R9 alloc after retire", sq_tail_o, bt);
      issue(3'd3, bt, 32'h7000, 1'b0, "R9 new store stalls");
      issue(3'd3, bt - 4'd1, 32'h7000, 1'b1, "R9 older resolved grant");
      resolve(ta, 32'h9100);
      for (int k = 0; k < 8; k++) retire();

      // R10 flush
      t0 = bt[2:0];
      start = bt;
      alloc(); alloc(); alloc();
      flush_i = 1'b1; flush_tag_i = t0; step(); flush_i = 1'b0;
      bt = start + 4'd1;
      chk("R10 tail after flush", sq_tail_o, bt);
      issue(3'd4, bt, 32'hA000, 1'b0, "R10 survivor stalls");
      resolve(t0, 32'hB000);
      issue(3'd4, bt, 32'hA000, 1'b1, "R10 flushed stores gone");
      alloc();
      chk("R10 alloc reuses slot", sq_tail_o, start + 4'd2);
      bypass_off_i = 1'b0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule